// File: doc/BRIEF.md
# Test Port Instruction Register and Scan Path Select

This block sits behind a JTAG test access port and holds everything that depends on the current instruction. An external TAP controller supplies capture, shift and update strobes for the instruction path and for the data path. The block keeps the instruction shift stage and the latched instruction, decodes the latched opcode, and routes the serial data path through one of three registers: a one-bit bypass cell, a 32-bit identification register, or a boundary chain that lives outside the block and is reached through a strobe/serial-out port.

The decoded instruction also drives four mode outputs. These tell the pin logic whether it is sampling, whether the scanned boundary data controls the pins, whether outputs float, or whether outputs hold their boundary values. Opcodes are parameters with a 4-bit instruction by default. The all-ones code is the bypass instruction. No instruction is given the all-zero code, so a scan input stuck low lands in bypass. Every code outside the map also falls back to bypass.

There is no data stream here. The serial path moves one bit per test clock under the strobes, so the ports are plain control pins and have no valid/ready handshake.

Top module: `jtag_instr_path`

## Requirements
- R1: After test reset (trst_n low) the latched instruction is IDCODE (code 0011), so a data capture followed by 32 shifts returns the identification value on tdo, least significant bit first.
- R2: An instruction capture loads the instruction shift stage with binary 01 in its low two bits and zeros above. Shifting then presents that stage on tdo, least significant bit first, and takes tdi in at the top.
- R3: The latched instruction, and with it the mode outputs and the data path, changes only on an instruction update. A capture and shift with no update leaves them unchanged.
- R4: BYPASS (all ones, 1111) selects a single-bit register. It captures 0, and while shifting tdo shows the tdi value of the previous shift cycle.
- R5: Codes outside the map, including 0000, act as BYPASS and assert no mode output.
- R6: HIGHZ (0100) and CLAMP (0101) use the bypass register as the scan path and assert mode_float and mode_hold respectively.
- R7: EXTEST (0110) and SAMPLE (0010) route the data path to the boundary port: tdo follows bsr_so while shifting. Only EXTEST asserts mode_pins_ctl. SAMPLE asserts mode_sample. At most one mode output is high at any time.
- R8: The identification register is 32 bits long and its least significant bit always captures as 1. Bits shifted in at tdi come out on tdo after exactly 32 shifts.
- R9: bsr_capture, bsr_shift and bsr_update copy the data-path strobes while a boundary instruction is latched, and stay low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial test data in |
| ir_capture | input | 1 | Instruction capture strobe |
| ir_shift | input | 1 | Instruction shift strobe |
| ir_update | input | 1 | Instruction update strobe |
| dr_capture | input | 1 | Data capture strobe |
| dr_shift | input | 1 | Data shift strobe |
| dr_update | input | 1 | Data update strobe |
| bsr_so | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial test data out |
| bsr_capture | output | 1 | Capture strobe to the boundary chain |
| bsr_shift | output | 1 | Shift strobe to the boundary chain |
| bsr_update | output | 1 | Update strobe to the boundary chain |
| mode_sample | output | 1 | Sample instruction active |
| mode_pins_ctl | output | 1 | Boundary data controls the pins |
| mode_float | output | 1 | Outputs forced to high impedance |
| mode_hold | output | 1 | Outputs held from boundary values |

## Verification
The hardest cases to reach from the ports are the codes nobody would normally load. These are the all-zero code that a stuck-low scan input produces and the gaps in the opcode map. The bench reaches them by sweeping all sixteen 4-bit codes through complete instruction scans and checking the mode outputs and the real scan length for each one. It also runs an instruction scan with no update to show that a shifted but unlatched code changes nothing.

// File: rtl/jtag_sel_pkg.sv
package jtag_sel_pkg;
  localparam int ID_W = 32;

  typedef enum logic [1:0] {
    PATH_BYPASS   = 2'd0,
    PATH_IDCODE   = 2'd1,
    PATH_BOUNDARY = 2'd2
  } dr_path_e;

  typedef struct packed {
    dr_path_e path;
    logic     sample;
    logic     pins_ctl;
    logic     float_out;
    logic     hold_out;
  } instr_dec_t;
endpackage

// File: rtl/jtag_ir_stage.sv
module jtag_ir_stage #(
  parameter int               IR_W     = 4,
  parameter logic [IR_W-1:0]  RST_CODE = IR_W'(3)
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  logic            capture,
  input  logic            shift,
  input  logic            update,
  output logic [IR_W-1:0] sr_q,
  output logic [IR_W-1:0] ir_q
);
  // low two bits fixed at 01, upper bits zero
  localparam logic [IR_W-1:0] CAP_PAT = IR_W'(1);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr_q <= '0;
    end else if (capture) begin
      sr_q <= CAP_PAT;
    end else if (shift) begin
      sr_q <= {tdi, sr_q[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_q <= RST_CODE;
    end else if (update) begin
      ir_q <= sr_q;
    end
  end
endmodule

// File: rtl/jtag_ir_decode.sv
module jtag_ir_decode
  import jtag_sel_pkg::*;
#(
  parameter int              IR_W      = 4,
  parameter logic [IR_W-1:0] OP_SAMPLE = IR_W'(2),
  parameter logic [IR_W-1:0] OP_IDCODE = IR_W'(3),
  parameter logic [IR_W-1:0] OP_HIGHZ  = IR_W'(4),
  parameter logic [IR_W-1:0] OP_CLAMP  = IR_W'(5),
  parameter logic [IR_W-1:0] OP_EXTEST = IR_W'(6)
) (
  input  logic [IR_W-1:0] opcode,
  output instr_dec_t      dec
);
  always_comb begin
    dec = '{path: PATH_BYPASS, sample: 1'b0, pins_ctl: 1'b0,
            float_out: 1'b0, hold_out: 1'b0};
    if (opcode == OP_EXTEST) begin
      dec.path     = PATH_BOUNDARY;
      dec.pins_ctl = 1'b1;
    end else if (opcode == OP_SAMPLE) begin
      dec.path   = PATH_BOUNDARY;
      dec.sample = 1'b1;
    end else if (opcode == OP_IDCODE) begin
      dec.path = PATH_IDCODE;
    end else if (opcode == OP_HIGHZ) begin
      dec.float_out = 1'b1;
    end else if (opcode == OP_CLAMP) begin
      dec.hold_out = 1'b1;
    end
    // all ones and every unmapped code: plain bypass
  end
endmodule

// File: rtl/jtag_dr_bank.sv
module jtag_dr_bank
  import jtag_sel_pkg::*;
#(
  parameter logic [ID_W-1:0] ID_VALUE = 32'h4BA0_0C72
) (
  input  logic     tck,
  input  logic     trst_n,
  input  logic     tdi,
  input  dr_path_e path,
  input  logic     capture,
  input  logic     shift,
  output logic     byp_q,
  output logic     id_lsb
);
  localparam logic [ID_W-1:0] ID_CAP = {ID_VALUE[ID_W-1:1], 1'b1};

  logic            byp_sel;
  logic            id_sel;
  logic [ID_W-1:0] id_q;

  assign byp_sel = (path == PATH_BYPASS);
  assign id_sel  = (path == PATH_IDCODE);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q <= 1'b0;
    end else if (byp_sel && capture) begin
      byp_q <= 1'b0;
    end else if (byp_sel && shift) begin
      byp_q <= tdi;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      id_q <= '0;
    end else if (id_sel && capture) begin
      id_q <= ID_CAP;
    end else if (id_sel && shift) begin
      id_q <= {tdi, id_q[ID_W-1:1]};
    end
  end

  assign id_lsb = id_q[0];
endmodule

// File: rtl/jtag_instr_path.sv
module jtag_instr_path
  import jtag_sel_pkg::*;
#(
  parameter int              IR_W      = 4,
  parameter logic [IR_W-1:0] OP_SAMPLE = IR_W'(2),
  parameter logic [IR_W-1:0] OP_IDCODE = IR_W'(3),
  parameter logic [IR_W-1:0] OP_HIGHZ  = IR_W'(4),
  parameter logic [IR_W-1:0] OP_CLAMP  = IR_W'(5),
  parameter logic [IR_W-1:0] OP_EXTEST = IR_W'(6),
  parameter logic [ID_W-1:0] ID_VALUE  = 32'h4BA0_0C72
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tdi,
  input  logic ir_capture,
  input  logic ir_shift,
  input  logic ir_update,
  input  logic dr_capture,
  input  logic dr_shift,
  input  logic dr_update,
  input  logic bsr_so,
  output logic tdo,
  output logic bsr_capture,
  output logic bsr_shift,
  output logic bsr_update,
  output logic mode_sample,
  output logic mode_pins_ctl,
  output logic mode_float,
  output logic mode_hold
);
  logic [IR_W-1:0] ir_sr;
  logic [IR_W-1:0] ir_q;
  instr_dec_t      dec;
  dr_path_e        path;
  logic            byp_q;
  logic            id_lsb;
  logic            dr_so;
  logic            bsr_sel;

  jtag_ir_stage #(.IR_W(IR_W), .RST_CODE(OP_IDCODE)) u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .capture(ir_capture), .shift(ir_shift), .update(ir_update),
    .sr_q(ir_sr), .ir_q(ir_q)
  );

  jtag_ir_decode #(
    .IR_W(IR_W), .OP_SAMPLE(OP_SAMPLE), .OP_IDCODE(OP_IDCODE),
    .OP_HIGHZ(OP_HIGHZ), .OP_CLAMP(OP_CLAMP), .OP_EXTEST(OP_EXTEST)
  ) u_dec (
    .opcode(ir_q), .dec(dec)
  );

  assign path = dec.path;

  jtag_dr_bank #(.ID_VALUE(ID_VALUE)) u_bank (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .path(path),
    .capture(dr_capture), .shift(dr_shift),
    .byp_q(byp_q), .id_lsb(id_lsb)
  );

  always_comb begin
    unique case (path)
      PATH_IDCODE:   dr_so = id_lsb;
      PATH_BOUNDARY: dr_so = bsr_so;
      default:       dr_so = byp_q;
    endcase
  end

  assign tdo = ir_shift ? ir_sr[0] : dr_so;

  assign bsr_sel     = (path == PATH_BOUNDARY);
  assign bsr_capture = bsr_sel & dr_capture;
  assign bsr_shift   = bsr_sel & dr_shift;
  assign bsr_update  = bsr_sel & dr_update;

  assign mode_sample   = dec.sample;
  assign mode_pins_ctl = dec.pins_ctl;
  assign mode_float    = dec.float_out;
  assign mode_hold     = dec.hold_out;
endmodule

// File: rtl/jtag_instr_path_chk.sv
module jtag_instr_path_chk #(
  parameter int              IR_W      = 4,
  parameter logic [IR_W-1:0] OP_SAMPLE = IR_W'(2),
  parameter logic [IR_W-1:0] OP_IDCODE = IR_W'(3),
  parameter logic [IR_W-1:0] OP_HIGHZ  = IR_W'(4),
  parameter logic [IR_W-1:0] OP_CLAMP  = IR_W'(5),
  parameter logic [IR_W-1:0] OP_EXTEST = IR_W'(6)
) (
  input logic            tck,
  input logic            trst_n,
  input logic            tdi,
  input logic            ir_capture,
  input logic            ir_update,
  input logic            dr_capture,
  input logic            dr_shift,
  input logic            bsr_capture,
  input logic            bsr_shift,
  input logic            bsr_update,
  input logic            mode_sample,
  input logic            mode_pins_ctl,
  input logic            mode_float,
  input logic            mode_hold,
  input logic [IR_W-1:0] ir_sr,
  input logic [IR_W-1:0] ir_q,
  input logic [1:0]      path,
  input logic            byp_q
);
  logic known_op;
  assign known_op = (ir_q == OP_SAMPLE) || (ir_q == OP_IDCODE) ||
                    (ir_q == OP_HIGHZ)  || (ir_q == OP_CLAMP)  ||
                    (ir_q == OP_EXTEST);

  p_ir_cap_r2: assert property (@(posedge tck) disable iff (!trst_n)
    ir_capture |=> (ir_sr[1:0] == 2'b01));

  p_ir_hold_r3: assert property (@(posedge tck) disable iff (!trst_n)
    !ir_update |=> $stable(ir_q));

  p_byp_cap_r4: assert property (@(posedge tck) disable iff (!trst_n)
    (path == 2'd0 && dr_capture) |=> (byp_q == 1'b0));

  p_byp_shift_r4: assert property (@(posedge tck) disable iff (!trst_n)
    (path == 2'd0 && dr_shift && !dr_capture) |=> (byp_q == $past(tdi)));

  p_unknown_byp_r5: assert property (@(posedge tck) disable iff (!trst_n)
    !known_op |-> (path == 2'd0 && !mode_sample && !mode_pins_ctl &&
                   !mode_float && !mode_hold));

  p_float_hold_byp_r6: assert property (@(posedge tck) disable iff (!trst_n)
    (mode_float || mode_hold) |-> (path == 2'd0));

  p_modes_onehot_r7: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({mode_sample, mode_pins_ctl, mode_float, mode_hold}));

  p_pins_ctl_bsr_r7: assert property (@(posedge tck) disable iff (!trst_n)
    (mode_pins_ctl || mode_sample) |-> (path == 2'd2));

  p_bsr_gate_r9: assert property (@(posedge tck) disable iff (!trst_n)
    !(mode_pins_ctl || mode_sample) |-> (!bsr_capture && !bsr_shift && !bsr_update));
endmodule

bind jtag_instr_path jtag_instr_path_chk #(
  .IR_W(IR_W), .OP_SAMPLE(OP_SAMPLE), .OP_IDCODE(OP_IDCODE),
  .OP_HIGHZ(OP_HIGHZ), .OP_CLAMP(OP_CLAMP), .OP_EXTEST(OP_EXTEST)
) u_chk (
  .tck(tck), .trst_n(trst_n), .tdi(tdi),
  .ir_capture(ir_capture), .ir_update(ir_update),
  .dr_capture(dr_capture), .dr_shift(dr_shift),
  .bsr_capture(bsr_capture), .bsr_shift(bsr_shift), .bsr_update(bsr_update),
  .mode_sample(mode_sample), .mode_pins_ctl(mode_pins_ctl),
  .mode_float(mode_float), .mode_hold(mode_hold),
  .ir_sr(ir_sr), .ir_q(ir_q), .path(path), .byp_q(byp_q)
);

// File: tb/tb_jtag_instr_path.sv
module tb_jtag_instr_path;
  localparam logic [31:0] ID_RAW = 32'h4BA0_0C72;
  localparam logic [31:0] ID_EXP = 32'h4BA0_0C73;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tdi = 1'b0;
  logic ir_capture = 1'b0, ir_shift = 1'b0, ir_update = 1'b0;
  logic dr_capture = 1'b0, dr_shift = 1'b0, dr_update = 1'b0;
  logic bsr_so = 1'b0;
  logic tdo, bsr_capture, bsr_shift, bsr_update;
  logic mode_sample, mode_pins_ctl, mode_float, mode_hold;

  int total = 0;
  int bad = 0;

  always #5 tck = ~tck;

  jtag_instr_path #(.ID_VALUE(ID_RAW)) dut (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .ir_capture(ir_capture), .ir_shift(ir_shift), .ir_update(ir_update),
    .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
    .bsr_so(bsr_so), .tdo(tdo),
    .bsr_capture(bsr_capture), .bsr_shift(bsr_shift), .bsr_update(bsr_update),
    .mode_sample(mode_sample), .mode_pins_ctl(mode_pins_ctl),
    .mode_float(mode_float), .mode_hold(mode_hold)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] got,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge tck);
    #1;
  endtask

  task automatic ir_scan(input logic [3:0] op, input bit do_upd,
                         output logic [3:0] cap);
    ir_capture = 1'b1;
    step();
    ir_capture = 1'b0;
    ir_shift = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tdi = op[i];
      #1 cap[i] = tdo;
      step();
    end
    ir_shift = 1'b0;
    if (do_upd) begin
      ir_update = 1'b1;
      step();
      ir_update = 1'b0;
    end
  endtask

  task automatic dr_scan32(input logic [31:0] din, output logic [31:0] dout);
    dr_capture = 1'b1;
    step();
    dr_capture = 1'b0;
    dr_shift = 1'b1;
    for (int i = 0; i < 32; i++) begin
      tdi = din[i];
      #1 dout[i] = tdo;
      step();
    end
    dr_shift = 1'b0;
    dr_update = 1'b1;
    step();
    dr_update = 1'b0;
  endtask

  function automatic logic [4:0] exp_modes(input logic [3:0] op);
    // {is_boundary, sample, pins_ctl, float, hold}
    case (op)
      4'b0010: return 5'b11000;
      4'b0110: return 5'b10100;
      4'b0100: return 5'b00010;
      4'b0101: return 5'b00001;
      default: return 5'b00000;
    endcase
  endfunction

  initial begin
    #1500000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0]  cap;
    logic [31:0] dout;
    logic [4:0]  em;
    logic [3:0]  gotm;

    repeat (3) step();
    chk({mode_sample, mode_pins_ctl, mode_float, mode_hold} == 4'b0, "R1 reset modes",
        {28'd0, mode_sample, mode_pins_ctl, mode_float, mode_hold}, 32'd0);
    trst_n = 1'b1;
    step();

    // R1 / R8: first data scan after reset reads the identification value
    dr_scan32(32'hC3A5_0F96, dout);
    chk(dout == ID_EXP, "R1 id after reset", dout, ID_EXP);
    dr_scan32(32'h0, dout);
    chk(dout == ID_EXP, "R8 id recapture lsb=1", dout, ID_EXP);
    // R8: bits shifted in come back after exactly 32 shifts
    dr_capture = 1'b1; step(); dr_capture = 1'b0;
    dr_shift = 1'b1;
    for (int i = 0; i < 32; i++) begin
      tdi = (i % 3 == 0); step();
    end
    for (int i = 0; i < 32; i++) begin
      tdi = 1'b0;
      #1 dout[i] = tdo;
      step();
    end
    dr_shift = 1'b0;
    begin
      logic [31:0] pat;
      for (int i = 0; i < 32; i++) pat[i] = (i % 3 == 0);
      chk(dout == pat, "R8 32-bit length", dout, pat);
    end

    // sweep all sixteen instruction codes
    for (int op = 0; op < 16; op++) begin
      ir_scan(op[3:0], 1'b1, cap);
      chk(cap == 4'b0001, "R2 ir capture 01", {28'd0, cap}, 32'd1);
      em = exp_modes(op[3:0]);
      gotm = {mode_sample, mode_pins_ctl, mode_float, mode_hold};
      chk(gotm == em[3:0], (em[3:0] == 4'b0) ? "R5 modes" : "R6/R7 modes",
          {28'd0, gotm}, {28'd0, em[3:0]});
      if (op == 3) begin
        dr_scan32(32'h0, dout);
        chk(dout == ID_EXP, "R1 idcode reload", dout, ID_EXP);
      end else if (em[4]) begin
        dr_capture = 1'b1;
        #1 chk(bsr_capture == 1'b1, "R9 bsr capture follows", {31'd0, bsr_capture}, 32'd1);
        step();
        dr_capture = 1'b0;
        dr_shift = 1'b1;
        for (int k = 0; k < 4; k++) begin
          bsr_so = k[0];
          #1 chk(tdo == k[0] && bsr_shift, "R7 boundary path",
                 {30'd0, bsr_shift, tdo}, {30'd0, 1'b1, k[0]});
          step();
        end
        dr_shift = 1'b0;
        dr_update = 1'b1;
        #1 chk(bsr_update == 1'b1, "R9 bsr update follows", {31'd0, bsr_update}, 32'd1);
        step();
        dr_update = 1'b0;
      end else begin
        // bypass-class: one-bit delay, capture 0, boundary strobes idle
        dr_capture = 1'b1;
        #1 chk(bsr_capture == 1'b0, "R9 bsr capture gated", {31'd0, bsr_capture}, 32'd0);
        step();
        dr_capture = 1'b0;
        dr_shift = 1'b1;
        begin
          logic [2:0] din = 3'b101;
          logic [2:0] got;
          for (int k = 0; k < 3; k++) begin
            tdi = din[k];
            bsr_so = 1'b1;
            #1 got[k] = tdo;
            chk(bsr_shift == 1'b0, "R9 bsr shift gated", {31'd0, bsr_shift}, 32'd0);
            step();
          end
          chk(got == 3'b010, (op == 15) ? "R4 bypass delay" :
              ((em[1:0] != 0) ? "R6 bypass path" : "R5 bypass path"),
              {29'd0, got}, 32'd2);
        end
        dr_shift = 1'b0;
      end
    end

    // R3: shift a new code without update; nothing changes
    ir_scan(4'b0110, 1'b1, cap);
    chk(mode_pins_ctl == 1'b1, "R7 extest loaded", {31'd0, mode_pins_ctl}, 32'd1);
    ir_scan(4'b0100, 1'b0, cap);
    repeat (2) step();
    gotm = {mode_sample, mode_pins_ctl, mode_float, mode_hold};
    chk(gotm == 4'b0100, "R3 no update keeps instr", {28'd0, gotm}, 32'h4);
    ir_update = 1'b1; step(); ir_update = 1'b0;
    gotm = {mode_sample, mode_pins_ctl, mode_float, mode_hold};
    chk(gotm == 4'b0010, "R3 update applies", {28'd0, gotm}, 32'h2);

    // R1: a fresh test reset returns to IDCODE
    trst_n = 1'b0; step(); trst_n = 1'b1; step();
    dr_scan32(32'h0, dout);
    chk(dout == ID_EXP, "R1 id after second reset", dout, ID_EXP);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule